// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block is a hardware sequencer that searches a management bus for the first PHY that answers. After a start pulse it uses a management-master command interface to probe each PHY address in ascending order. At each address it reads the upper identifier register. An all-ones value, or a read that the master reports as timed out, means nothing is present at that address. At the first address that answers, the block also reads the lower identifier register. It then reports the address and the 32-bit identifier.

A PHY that comes out of reset slowly may miss the first sweep. If a full sweep finds nothing, the block waits a fixed number of microsecond ticks and sweeps again, up to a fixed number of sweeps. When every sweep fails, it raises a failure flag and keeps the found flag low, so the reported address is marked invalid.

A discovered PHY is cached. Later start pulses complete at once and do not touch the bus. Only reset clears the cache.

Top module: `mdio_phy_scanner`

## Requirements
- R1: After reset, found, fail, done and mgmt_req are all low.
- R2: A sweep probes addresses 0 to 31 in strictly ascending order, reading register 2 (the upper identifier). While mgmt_req is high and mgmt_done is low, mgmt_phy and mgmt_reg hold steady. A cycle with mgmt_req high after a mgmt_done cycle is a new request.
- R3: A register 2 value of 0xFFFF marks the address as empty, and the sweep moves to the next address.
- R4: A register 2 read that completes with mgmt_timeout high marks the address as empty, whatever data comes with it.
- R5: At a responding address the block reads register 3 at the same address. It then sets found and phy_addr, and sets phy_id with register 2 in bits 31:16 and register 3 in bits 15:0. A timed-out register 3 read contributes 0xFFFF. done pulses for exactly one cycle, with mgmt_req low in that cycle.
- R6: After the first responding address, no further addresses are probed.
- R7: No wait comes before the first sweep. Before each later sweep, mgmt_req stays low for WAIT_US us_tick pulses.
- R8: After MAX_PASSES sweeps with no response (MAX_PASSES × 32 register 2 reads and no register 3 read), fail rises, found stays low and done pulses once.
- R9: When found is high, a start pulse gives a done pulse in the next cycle. No request is issued, and phy_addr and phy_id do not change.
- R10: A start pulse during a scan is ignored. This includes a start in the same cycle as the final register 3 completion: there is no second done pulse and no extra read.
- R11: After a failure, a new start clears fail and runs a fresh scan from address 0 and sweep 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request to discover a PHY |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| mgmt_req | output | 1 | Register read request to the management master |
| mgmt_phy | output | ADDR_W | PHY address of the request |
| mgmt_reg | output | 5 | Register number of the request |
| mgmt_done | input | 1 | Single-cycle completion of the current request |
| mgmt_rdata | input | 16 | Read data, valid with mgmt_done |
| mgmt_timeout | input | 1 | The completed read got no answer |
| found | output | 1 | A PHY address is known; phy_addr is valid |
| phy_addr | output | ADDR_W | Discovered PHY address |
| phy_id | output | 32 | Discovered identifier {reg2, reg3} |
| done | output | 1 | One-cycle pulse when a discovery request finishes |
| fail | output | 1 | The last scan found no PHY |

## Verification
Two events can land in the same cycle: a new start pulse and the completion that ends a scan. The bench's management model raises start in exactly the cycle it returns the register 3 data. In that cycle the sequencer is still busy, so the start must not take the cached-result path or begin another scan. The check is judged by exactly one done pulse, one register 3 read, and a register 2 read count that stops at the responding address. A second start pulse in the middle of the sweep is judged the same way.

// File: rtl/mdio_scan_pkg.sv
package mdio_scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROBE,
        ST_IDLO,
        ST_GAP
    } scan_state_t;

    localparam logic [15:0] EMPTY_WORD = 16'hFFFF;

    typedef struct packed {
        logic [15:0] hi;
        logic [15:0] lo;
    } phy_ident_t;

    function automatic logic slot_empty(input logic [15:0] rdata, input logic timed_out);
        return timed_out || (rdata == EMPTY_WORD);
    endfunction

endpackage

// File: rtl/mdio_scan_cursor.sv
module mdio_scan_cursor #(
    parameter int ADDR_W     = 5,
    parameter int MAX_PASSES = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              next_addr,
    input  logic              next_pass,
    output logic [ADDR_W-1:0] addr,
    output logic              last_addr,
    output logic              last_pass
);
    localparam int PASS_W = (MAX_PASSES > 1) ? $clog2(MAX_PASSES) : 1;

    logic [PASS_W-1:0] pass_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            addr   <= '0;
            pass_q <= '0;
        end else if (next_pass) begin
            addr   <= '0;
            pass_q <= pass_q + 1'b1;
        end else if (next_addr) begin
            addr <= addr + 1'b1;
        end
    end

    assign last_addr = (addr == {ADDR_W{1'b1}});
    assign last_pass = (pass_q == PASS_W'(MAX_PASSES - 1));
endmodule

// File: rtl/mdio_scan_gap_timer.sv
module mdio_scan_gap_timer #(
    parameter int WAIT_US = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CNT_W = $clog2(WAIT_US + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == CNT_W'(WAIT_US));
endmodule

// File: rtl/mdio_phy_scanner.sv
module mdio_phy_scanner
    import mdio_scan_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int MAX_PASSES = 11,
    parameter int WAIT_US    = 10000,
    parameter int ID_HI_REG  = 2,
    parameter int ID_LO_REG  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              us_tick,
    output logic              mgmt_req,
    output logic [ADDR_W-1:0] mgmt_phy,
    output logic [4:0]        mgmt_reg,
    input  logic              mgmt_done,
    input  logic [15:0]       mgmt_rdata,
    input  logic              mgmt_timeout,
    output logic              found,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [31:0]       phy_id,
    output logic              done,
    output logic              fail
);
    scan_state_t       st_q, st_d;
    logic              cur_clear, cur_next_addr, cur_next_pass;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_last_addr, cur_last_pass;
    logic              gap_expired;
    logic              probe_empty;
    logic [15:0]       hi_q;
    phy_ident_t        ident;

    mdio_scan_cursor #(
        .ADDR_W    (ADDR_W),
        .MAX_PASSES(MAX_PASSES)
    ) u_cursor (
        .clk      (clk),
        .rst      (rst),
        .clear    (cur_clear),
        .next_addr(cur_next_addr),
        .next_pass(cur_next_pass),
        .addr     (cur_addr),
        .last_addr(cur_last_addr),
        .last_pass(cur_last_pass)
    );

    mdio_scan_gap_timer #(
        .WAIT_US(WAIT_US)
    ) u_gap (
        .clk    (clk),
        .rst    (rst),
        .run    (st_q == ST_GAP),
        .tick   (us_tick),
        .expired(gap_expired)
    );

    assign probe_empty = slot_empty(mgmt_rdata, mgmt_timeout);

    always_comb begin
        st_d          = st_q;
        cur_clear     = 1'b0;
        cur_next_addr = 1'b0;
        cur_next_pass = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start && !found) begin
                    st_d      = ST_PROBE;
                    cur_clear = 1'b1;
                end
            end
            ST_PROBE: begin
                if (mgmt_done) begin
                    if (!probe_empty) begin
                        st_d = ST_IDLO;
                    end else if (!cur_last_addr) begin
                        cur_next_addr = 1'b1;
                    end else if (cur_last_pass) begin
                        st_d = ST_IDLE;
                    end else begin
                        st_d          = ST_GAP;
                        cur_next_pass = 1'b1;
                    end
                end
            end
            ST_IDLO: begin
                if (mgmt_done) st_d = ST_IDLE;
            end
            ST_GAP: begin
                if (gap_expired) st_d = ST_PROBE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ident.hi = hi_q;
        ident.lo = mgmt_timeout ? EMPTY_WORD : mgmt_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            found    <= 1'b0;
            fail     <= 1'b0;
            done     <= 1'b0;
            hi_q     <= '0;
            phy_addr <= '0;
            phy_id   <= '0;
        end else begin
            st_q <= st_d;
            done <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        if (found) done <= 1'b1;
                        else       fail <= 1'b0;
                    end
                end
                ST_PROBE: begin
                    if (mgmt_done) begin
                        if (!probe_empty) begin
                            hi_q <= mgmt_rdata;
                        end else if (cur_last_addr && cur_last_pass) begin
                            fail <= 1'b1;
                            done <= 1'b1;
                        end
                    end
                end
                ST_IDLO: begin
                    if (mgmt_done) begin
                        phy_id   <= ident;
                        phy_addr <= cur_addr;
                        found    <= 1'b1;
                        done     <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign mgmt_req = (st_q == ST_PROBE) || (st_q == ST_IDLO);
    assign mgmt_phy = cur_addr;
    assign mgmt_reg = (st_q == ST_IDLO) ? 5'(ID_LO_REG) : 5'(ID_HI_REG);
endmodule

// File: rtl/mdio_phy_scanner_chk.sv
module mdio_phy_scanner_chk #(
    parameter int ADDR_W    = 5,
    parameter int ID_HI_REG = 2,
    parameter int ID_LO_REG = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mgmt_req,
    input logic [ADDR_W-1:0] mgmt_phy,
    input logic [4:0]        mgmt_reg,
    input logic              mgmt_done,
    input logic              found,
    input logic [ADDR_W-1:0] phy_addr,
    input logic [31:0]       phy_id,
    input logic              done,
    input logic              fail
);
    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) && !rst |-> !found && !fail && !done && !mgmt_req);

    // R2
    a_r2_request_held: assert property (@(posedge clk) disable iff (rst)
        mgmt_req && !mgmt_done |=> mgmt_req && $stable(mgmt_phy) && $stable(mgmt_reg));

    // R2
    a_r2_legal_register: assert property (@(posedge clk) disable iff (rst)
        mgmt_req |-> (mgmt_reg == 5'(ID_HI_REG)) || (mgmt_reg == 5'(ID_LO_REG)));

    // R3
    a_r3_id_upper_valid: assert property (@(posedge clk) disable iff (rst)
        found |-> phy_id[31:16] != 16'hFFFF);

    // R5
    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    a_r5_done_bus_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !mgmt_req);

    // R8
    a_r8_found_fail_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(found && fail));

    // R9
    a_r9_cache_no_bus: assert property (@(posedge clk) disable iff (rst)
        found |-> !mgmt_req);

    // R9
    a_r9_cache_answer: assert property (@(posedge clk) disable iff (rst)
        found && start |=> done && $stable(phy_addr) && $stable(phy_id));
endmodule

bind mdio_phy_scanner mdio_phy_scanner_chk #(
    .ADDR_W   (ADDR_W),
    .ID_HI_REG(ID_HI_REG),
    .ID_LO_REG(ID_LO_REG)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mgmt_req (mgmt_req),
    .mgmt_phy (mgmt_phy),
    .mgmt_reg (mgmt_reg),
    .mgmt_done(mgmt_done),
    .found    (found),
    .phy_addr (phy_addr),
    .phy_id   (phy_id),
    .done     (done),
    .fail     (fail)
);

// File: tb/test_mdio_phy_scanner.sv
`timescale 1ns/1ps
module test_mdio_phy_scanner;
    localparam int ADDR_W = 5;
    localparam int PASSES = 11;
    localparam int WAITU  = 20;
    localparam int LAT    = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        us_tick = 1'b0;
    logic        mgmt_req;
    logic [4:0]  mgmt_phy;
    logic [4:0]  mgmt_reg;
    logic        mgmt_done = 1'b0;
    logic [15:0] mgmt_rdata = '0;
    logic        mgmt_timeout = 1'b0;
    logic        found;
    logic [4:0]  phy_addr;
    logic [31:0] phy_id;
    logic        done;
    logic        fail;

    always #2.5 clk = ~clk;

    mdio_phy_scanner #(
        .ADDR_W(ADDR_W), .MAX_PASSES(PASSES), .WAIT_US(WAITU),
        .ID_HI_REG(2), .ID_LO_REG(3)
    ) i_mdio_phy_scanner (
        .clk(clk), .rst(rst), .start(start), .us_tick(us_tick),
        .mgmt_req(mgmt_req), .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
        .mgmt_done(mgmt_done), .mgmt_rdata(mgmt_rdata), .mgmt_timeout(mgmt_timeout),
        .found(found), .phy_addr(phy_addr), .phy_id(phy_id), .done(done), .fail(fail)
    );

    int total = 0;
    int bad   = 0;

    // management PHY model state
    logic        present [32];
    logic        tout    [32];
    logic [15:0] mhi     [32];
    logic [15:0] mlo     [32];
    int          wake_at [32];
    int          reads_hi, reads_lo, order_err, exp_next, lo_addr;
    int          done_cnt, wait_ticks, lat, tick_div;
    bit          scan_on, start_on_lo, drop_start;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < 32; i++) begin
            present[i] = 1'b0; tout[i] = 1'b0; wake_at[i] = 0;
            mhi[i] = 16'hFFFF; mlo[i] = 16'hFFFF;
        end
        reads_hi = 0; reads_lo = 0; order_err = 0; exp_next = 0; lo_addr = -1;
        done_cnt = 0; wait_ticks = 0; start_on_lo = 1'b0;
    endtask

    task automatic clear_counts();
        reads_hi = 0; reads_lo = 0; order_err = 0; exp_next = 0;
        done_cnt = 0; wait_ticks = 0;
    endtask

    initial begin : model
        lat = 0; tick_div = 0; scan_on = 1'b0; drop_start = 1'b0;
        forever begin
            @(negedge clk);
            mgmt_done = 1'b0;
            mgmt_timeout = 1'b0;
            if (drop_start) begin start = 1'b0; drop_start = 1'b0; end
            if (done) done_cnt++;
            if (us_tick && scan_on && !mgmt_req) wait_ticks++;
            tick_div = (tick_div + 1) % 4;
            us_tick = (tick_div == 0);
            if (rst) lat = 0;
            else if (mgmt_req) begin
                lat++;
                if (lat >= LAT) begin
                    int a;
                    lat = 0;
                    a = int'(mgmt_phy);
                    mgmt_done = 1'b1;
                    if (mgmt_reg == 5'd2) begin
                        reads_hi++;
                        if (a != exp_next) order_err++;
                        exp_next = (a + 1) % 32;
                        mgmt_rdata = (present[a] && reads_hi >= wake_at[a]) ? mhi[a] : 16'hFFFF;
                        mgmt_timeout = tout[a];
                    end else begin
                        reads_lo++;
                        lo_addr = a;
                        mgmt_rdata = mlo[a];
                        if (start_on_lo) begin start = 1'b1; drop_start = 1'b1; end
                    end
                end
            end
        end
    end

    task automatic do_reset();
        clear_model();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // pulses start and waits for done; returns cycles after the start cycle
    task automatic run_scan(input int mid_start_at, output int cyc);
        @(negedge clk); start = 1'b1; scan_on = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (cyc == mid_start_at) start = 1'b1;
            else if (cyc == mid_start_at + 1) start = 1'b0;
        end
        scan_on = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(!found && !fail && !done && !mgmt_req, "R1 idle outputs after reset",
            {found, fail, done, mgmt_req}, 0);
    endtask

    task automatic t_first_phy();
        int cyc;
        do_reset();
        present[7] = 1'b1; mhi[7] = 16'h0022; mlo[7] = 16'h1619;
        present[12] = 1'b1; mhi[12] = 16'h1234; mlo[12] = 16'h5678;
        start_on_lo = 1'b1;
        run_scan(6, cyc);
        chk(found && !fail, "R5 found after scan", {found, fail}, 2'b10);
        chk(phy_addr == 5'd7, "R6 first responder address", phy_addr, 7);
        chk(phy_id == 32'h0022_1619, "R5 id composition", phy_id, 32'h0022_1619);
        chk(order_err == 0, "R2 ascending probe order", order_err, 0);
        chk(lo_addr == 7, "R5 register 3 read at same address", lo_addr, 7);
        repeat (20) @(negedge clk);
        chk(reads_hi == 8, "R10 R6 register 2 reads", reads_hi, 8);
        chk(reads_lo == 1, "R10 single register 3 read", reads_lo, 1);
        chk(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
    endtask

    task automatic t_cache();
        int cyc;
        logic [31:0] id0;
        logic [4:0]  a0;
        id0 = phy_id; a0 = phy_addr;
        start_on_lo = 1'b0;
        clear_counts();
        run_scan(-5, cyc);
        chk(cyc == 0, "R9 cached done next cycle", cyc, 0);
        repeat (10) @(negedge clk);
        chk(reads_hi == 0 && reads_lo == 0, "R9 no bus traffic on cached start", reads_hi + reads_lo, 0);
        chk(phy_id == id0 && phy_addr == a0, "R9 cached result unchanged", phy_id, id0);
    endtask

    task automatic t_absent_kinds();
        int cyc;
        do_reset();
        present[1] = 1'b1; tout[1] = 1'b1; mhi[1] = 16'h00AA;
        present[2] = 1'b1; mhi[2] = 16'hFFFF; mlo[2] = 16'h0000;
        present[4] = 1'b1; mhi[4] = 16'h0181; mlo[4] = 16'h4400;
        run_scan(-5, cyc);
        chk(phy_addr == 5'd4 && found, "R4 R3 timeout and all-ones skipped", phy_addr, 4);
        chk(reads_hi == 5, "R4 probes through address 4", reads_hi, 5);
        chk(phy_id == 32'h0181_4400, "R5 id at address 4", phy_id, 32'h0181_4400);
    endtask

    task automatic t_last_addr();
        int cyc;
        do_reset();
        present[31] = 1'b1; mhi[31] = 16'h2000; mlo[31] = 16'h5C90;
        run_scan(-5, cyc);
        chk(found && phy_addr == 5'd31, "R2 top address reachable", phy_addr, 31);
        chk(reads_hi == 32, "R2 full sweep count", reads_hi, 32);
        chk(wait_ticks == 0, "R7 no wait before first sweep", wait_ticks, 0);
    endtask

    task automatic t_slow_phy();
        int cyc;
        do_reset();
        present[5] = 1'b1; wake_at[5] = 70; mhi[5] = 16'h0040; mlo[5] = 16'h6322;
        run_scan(-5, cyc);
        chk(found && phy_addr == 5'd5, "R7 slow PHY found on third sweep", phy_addr, 5);
        chk(reads_hi == 70, "R7 register 2 reads over three sweeps", reads_hi, 70);
        chk(wait_ticks >= 2 * WAITU && wait_ticks <= 2 * WAITU + 2, "R7 gap length",
            wait_ticks, 2 * WAITU);
        chk(order_err == 0, "R2 order across sweeps", order_err, 0);
    endtask

    task automatic t_fail_then_retry();
        int cyc;
        do_reset();
        run_scan(-5, cyc);
        chk(fail && !found, "R8 failure reported", {fail, found}, 2'b10);
        chk(reads_hi == PASSES * 32, "R8 sweep limit", reads_hi, PASSES * 32);
        chk(reads_lo == 0, "R8 no register 3 read", reads_lo, 0);
        chk(wait_ticks >= (PASSES - 1) * WAITU && wait_ticks <= (PASSES - 1) * (WAITU + 1),
            "R7 gaps between failing sweeps", wait_ticks, (PASSES - 1) * WAITU);
        repeat (5) @(negedge clk);
        chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
        clear_counts();
        present[2] = 1'b1; mhi[2] = 16'h0016; mlo[2] = 16'hF870;
        run_scan(-5, cyc);
        chk(found && !fail && phy_addr == 5'd2, "R11 fresh scan after failure",
            {fail, found, phy_addr}, {2'b01, 5'd2});
        chk(reads_hi == 3, "R11 scan restarts at address 0", reads_hi, 3);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        clear_model();
        t_reset();
        t_first_phy();
        t_cache();
        t_absent_kinds();
        t_last_addr();
        t_slow_phy();
        t_fail_then_retry();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule